// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two independent guessers and a table of arbiters. The path-correlated guesser keeps saturating 2-bit counters, indexed by a shift register of recent branch outcomes across the whole program. The self-correlated guesser works in two levels. Low bits of the branch address pick an entry in a table of per-branch outcome histories. That history then indexes a table of saturating 3-bit counters. A table of 2-bit arbiter counters, indexed by the same global outcome register, decides which guess is final.

A fetch presents an address and gets a registered guess on the next cycle. The guess comes with a snapshot: the global index used, the local counter index used, and both component guesses. When the branch resolves, the front end returns that snapshot with the address and the real outcome. With this snapshot the block can train exactly the entries that made the guess. The outcome histories advance only at resolve time, so the block never has to repair a speculative history.

Top module: `tourney_predictor`

## Requirements
- R1: After a synchronous reset, `pred_valid` is 0. The global history is all zeros. Every local history is all zeros. Global counters start at 1, local counters at 3 and arbiter counters at 2. As a result, the first fetch reports `pred_gidx`=0, `pred_lidx`=0, `pred_gpred`=0, `pred_lpred`=0 and `pred_taken`=0.
- R2: `pred_valid` is `fetch_valid` delayed by one clock. The other prediction outputs are loaded only on a cycle with `fetch_valid` high.
- R3: Each resolve shifts `res_taken` into bit 0 of the global history, and the oldest bit drops off. Bit i therefore records the outcome i+1 resolves ago, with 1 meaning taken. `pred_gidx` shows the history as it stood at the fetch.
- R4: The local history entry is selected by PC bits [PC_LSB+LSEL_W-1:PC_LSB], with no tag check. A resolve shifts its outcome into bit 0 of the entry selected by `res_pc` and leaves all other entries unchanged. `pred_lidx` is the history of the entry selected by `fetch_pc`.
- R5: Global counters are 2-bit. They increment on taken and decrement on not-taken at `res_gidx`, saturating at 3 and 0. A counter predicts taken when its value is 2 or more.
- R6: Local counters are 3-bit. They increment on taken and decrement on not-taken at `res_lidx`, saturating at 7 and 0. A counter predicts taken when its value is 4 or more.
- R7: The arbiter counter is indexed by the global history. If its top bit is 1, `pred_taken` is the global guess; if it is 0, `pred_taken` is the local guess. When `res_gpred` and `res_lpred` differ, the arbiter entry at `res_gidx` moves toward whichever component matched `res_taken`, saturating at 3 and 0.
- R8: When `res_gpred` equals `res_lpred`, the arbiter entry stays unchanged whatever the outcome.
- R9: Every resolve updates both component counters, whichever component the arbiter selected.
- R10: When a fetch and a resolve occur in the same cycle, the prediction uses the state from before that resolve. The resolve still takes effect for later fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| pred_valid | output | 1 | Prediction outputs refer to last cycle's fetch |
| pred_taken | output | 1 | Final direction guess |
| pred_gpred | output | 1 | Global component guess (snapshot) |
| pred_lpred | output | 1 | Local component guess (snapshot) |
| pred_gidx | output | GHIST_W | Global history used as index (snapshot) |
| pred_lidx | output | LHIST_W | Local history used as counter index (snapshot) |
| res_valid | input | 1 | Resolve strobe |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_gidx | input | GHIST_W | Returned global index snapshot |
| res_lidx | input | LHIST_W | Returned local counter index snapshot |
| res_gpred | input | 1 | Returned global guess snapshot |
| res_lpred | input | 1 | Returned local guess snapshot |

## Verification
A lookup and a training update can land on the same clock edge, and they may touch the same global history, local history entry and counters. The bench provokes this by raising `fetch_valid` and `res_valid` together, with both aimed at the same address and at index 0. It then checks that the returned snapshot still shows the pre-update history and counter values. A follow-up fetch confirms that the update was not lost: both the global and the local history have advanced.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Arbiter decision encoded by the top bit of an arbiter counter.
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

  // Reset value of a counter that weakly leans not-taken.
  function automatic int weak_low(input int width);
    return (1 << (width - 1)) - 1;
  endfunction

  // Reset value of a counter that weakly leans toward its upper half.
  function automatic int weak_high(input int width);
    return 1 << (width - 1);
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 2,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX  = '1;
  localparam logic [CNT_W-1:0] CMIN  = '0;
  localparam logic [CNT_W-1:0] CINIT = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] cur, nxt;

  // Read-first: the read sees contents before this edge's write.
  assign rd_msb = mem[rd_idx][CNT_W-1];
  assign cur    = mem[wr_idx];

  always_comb begin
    nxt = cur;
    if (wr_up) begin
      if (cur != CMAX) nxt = cur + 1'b1;
    end else begin
      if (cur != CMIN) nxt = cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CINIT;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] old_h;

  assign rd_hist = mem[rd_idx];
  assign old_h   = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {old_h[HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int GHIST_W = 6,
  parameter int LSEL_W  = 4,
  parameter int LHIST_W = 5,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int CHCTR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_valid,
  input  logic [PC_W-1:0]    fetch_pc,
  output logic               pred_valid,
  output logic               pred_taken,
  output logic               pred_gpred,
  output logic               pred_lpred,
  output logic [GHIST_W-1:0] pred_gidx,
  output logic [LHIST_W-1:0] pred_lidx,
  input  logic               res_valid,
  input  logic [PC_W-1:0]    res_pc,
  input  logic               res_taken,
  input  logic [GHIST_W-1:0] res_gidx,
  input  logic [LHIST_W-1:0] res_lidx,
  input  logic               res_gpred,
  input  logic               res_lpred
);
  localparam int GRST  = weak_low(GCTR_W);
  localparam int LRST  = weak_low(LCTR_W);
  localparam int CHRST = weak_high(CHCTR_W);

  logic [GHIST_W-1:0] ghist;
  logic [LSEL_W-1:0]  f_sel, r_sel;
  logic [LHIST_W-1:0] f_lhist;
  logic               g_guess, l_guess, ch_msb;
  logic               ch_upd, ch_up;
  pick_e              pick;
  logic               unused_pc_bits;

  assign f_sel = fetch_pc[PC_LSB +: LSEL_W];
  assign r_sel = res_pc[PC_LSB +: LSEL_W];
  assign unused_pc_bits = ^{fetch_pc, res_pc};

  // Global outcome register, advanced only by resolved branches.
  always_ff @(posedge clk) begin
    if (rst) ghist <= '0;
    else if (res_valid) ghist <= {ghist[GHIST_W-2:0], res_taken};
  end

  tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCTR_W), .RST_VAL(GRST)) u_gpht (
    .clk(clk), .rst(rst),
    .rd_idx(ghist), .rd_msb(g_guess),
    .wr_en(res_valid), .wr_idx(res_gidx), .wr_up(res_taken)
  );

  tp_hist_table #(.IDX_W(LSEL_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst(rst),
    .rd_idx(f_sel), .rd_hist(f_lhist),
    .wr_en(res_valid), .wr_idx(r_sel), .wr_bit(res_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCTR_W), .RST_VAL(LRST)) u_lpht (
    .clk(clk), .rst(rst),
    .rd_idx(f_lhist), .rd_msb(l_guess),
    .wr_en(res_valid), .wr_idx(res_lidx), .wr_up(res_taken)
  );

  // Arbiter trains only when the components disagreed, toward the one that was right.
  assign ch_upd = res_valid && (res_gpred != res_lpred);
  assign ch_up  = (res_gpred == res_taken);

  tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(CHCTR_W), .RST_VAL(CHRST)) u_chooser (
    .clk(clk), .rst(rst),
    .rd_idx(ghist), .rd_msb(ch_msb),
    .wr_en(ch_upd), .wr_idx(res_gidx), .wr_up(ch_up)
  );

  assign pick = pick_e'(ch_msb);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_gpred <= 1'b0;
      pred_lpred <= 1'b0;
      pred_gidx  <= '0;
      pred_lidx  <= '0;
    end else begin
      pred_valid <= fetch_valid;
      if (fetch_valid) begin
        pred_taken <= (pick == PICK_GLOBAL) ? g_guess : l_guess;
        pred_gpred <= g_guess;
        pred_lpred <= l_guess;
        pred_gidx  <= ghist;
        pred_lidx  <= f_lhist;
      end
    end
  end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GHIST_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_valid,
  input logic               pred_valid,
  input logic               pred_taken,
  input logic               pred_gpred,
  input logic               pred_lpred,
  input logic [GHIST_W-1:0] pred_gidx,
  input logic [GHIST_W-1:0] ghist,
  input logic               res_valid
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !pred_valid);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid);

  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(ghist));

  // R3
  gidx_snap_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (pred_gidx == $past(ghist)));

  // R7
  agree_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && (pred_gpred == pred_lpred)) |-> (pred_taken == pred_gpred));
endmodule

bind tourney_predictor tp_checker #(.GHIST_W(GHIST_W)) u_tp_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_gpred(pred_gpred), .pred_lpred(pred_lpred),
  .pred_gidx(pred_gidx), .ghist(ghist), .res_valid(res_valid)
);

// File: tb/tb_tourney_predictor.sv
`timescale 1ns/1ps
module tb_tourney_predictor;
  localparam int PC_W = 32, GHIST_W = 6, LHIST_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic pred_valid, pred_taken, pred_gpred, pred_lpred;
  logic [GHIST_W-1:0] pred_gidx;
  logic [LHIST_W-1:0] pred_lidx;
  logic res_valid = 1'b0, res_taken = 1'b0, res_gpred = 1'b0, res_lpred = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic [GHIST_W-1:0] res_gidx = '0;
  logic [LHIST_W-1:0] res_lidx = '0;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  tourney_predictor dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_gpred(pred_gpred),
    .pred_lpred(pred_lpred), .pred_gidx(pred_gidx), .pred_lidx(pred_lidx),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_gidx(res_gidx), .res_lidx(res_lidx), .res_gpred(res_gpred),
    .res_lpred(res_lpred)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; fetch_valid = 1'b0; res_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_fetch(input logic [PC_W-1:0] pc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic do_resolve(input logic [PC_W-1:0] pc, input logic t, input int g,
                            input int l, input logic gp, input logic lp);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = t;
    res_gidx = GHIST_W'(g); res_lidx = LHIST_W'(l); res_gpred = gp; res_lpred = lp;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input logic t);
    int g, l;
    logic gp, lp;
    do_fetch(pc);
    g = int'(pred_gidx); l = int'(pred_lidx); gp = pred_gpred; lp = pred_lpred;
    do_resolve(pc, t, g, l, gp, lp);
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R1 pred_valid after reset", int'(pred_valid), 0);
    do_fetch(32'h100);
    chk("R2 pred_valid after fetch", int'(pred_valid), 1);
    chk("R1 gidx", int'(pred_gidx), 0);
    chk("R1 lidx", int'(pred_lidx), 0);
    chk("R1 gpred", int'(pred_gpred), 0);
    chk("R1 lpred", int'(pred_lpred), 0);
    chk("R1 taken", int'(pred_taken), 0);
    @(negedge clk);
    chk("R2 pred_valid drops", int'(pred_valid), 0);
  endtask

  task automatic t_global_hist();
    apply_reset();
    train(32'h40, 1'b1); train(32'h40, 1'b0); train(32'h40, 1'b1); train(32'h40, 1'b1);
    do_fetch(32'h100);
    chk("R3 global history T,N,T,T", int'(pred_gidx), 11);
  endtask

  task automatic t_local_hist();
    apply_reset();
    train(32'h40, 1'b1); train(32'h40, 1'b1); train(32'h40, 1'b0);
    train(32'h44, 1'b1);
    do_fetch(32'h40);
    chk("R4 local history entry 0", int'(pred_lidx), 6);
    do_fetch(32'h44);
    chk("R4 local history entry 1", int'(pred_lidx), 1);
    do_fetch(32'h80);
    chk("R4 untagged alias", int'(pred_lidx), 6);
    do_fetch(32'h48);
    chk("R4 untouched entry", int'(pred_lidx), 0);
  endtask

  task automatic t_global_ctr();
    apply_reset();
    for (int i = 0; i < 3; i++) do_resolve(32'h7C, 1'b0, 0, 30, 1'b0, 1'b0);
    do_fetch(32'h100);
    chk("R5 global counter floor", int'(pred_gpred), 0);
    for (int i = 0; i < 6; i++) do_resolve(32'h7C, 1'b1, 63, 30, 1'b0, 1'b0);
    do_fetch(32'h100);
    chk("R5 gidx all taken", int'(pred_gidx), 63);
    chk("R5 global counter taken", int'(pred_gpred), 1);
    do_resolve(32'h7C, 1'b0, 63, 30, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) do_resolve(32'h7C, 1'b1, 0, 30, 1'b0, 1'b0);
    do_fetch(32'h100);
    chk("R5 global counter ceiling", int'(pred_gpred), 1);
    chk("R7 global chosen by default", int'(pred_taken), 1);
  endtask

  task automatic t_local_ctr();
    apply_reset();
    do_resolve(32'h7C, 1'b1, 40, 0, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R6 local counter 4 is taken", int'(pred_lpred), 1);
    for (int i = 0; i < 5; i++) do_resolve(32'h7C, 1'b1, 40, 0, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R6 local counter ceiling", int'(pred_lpred), 1);
    for (int i = 0; i < 4; i++) do_resolve(32'h7C, 1'b0, 40, 0, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R6 local counter 3 not taken", int'(pred_lpred), 0);
    for (int i = 0; i < 4; i++) do_resolve(32'h7C, 1'b0, 40, 0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) do_resolve(32'h7C, 1'b1, 40, 0, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R6 local counter floor", int'(pred_lpred), 1);
  endtask

  task automatic t_chooser();
    apply_reset();
    do_resolve(32'h7C, 1'b1, 9, 0, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R9 local trained while global chosen", int'(pred_lpred), 1);
    chk("R7 default pick is global", int'(pred_taken), 0);
    do_resolve(32'h7C, 1'b0, 0, 9, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) do_resolve(32'h7C, 1'b0, 30, 30, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R9 global counter decremented", int'(pred_gpred), 0);
    chk("R7 arbiter moved to local", int'(pred_taken), 1);
    do_resolve(32'h7C, 1'b0, 0, 30, 1'b0, 1'b0);
    do_fetch(32'h40);
    chk("R8 arbiter holds on agreement", int'(pred_taken), 1);
    do_resolve(32'h7C, 1'b0, 0, 30, 1'b0, 1'b1);
    do_resolve(32'h7C, 1'b0, 0, 30, 1'b0, 1'b1);
    do_fetch(32'h40);
    chk("R7 arbiter moved to global", int'(pred_taken), 0);
  endtask

  task automatic t_same_cycle();
    apply_reset();
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 32'h40;
    res_valid = 1'b1; res_pc = 32'h40; res_taken = 1'b1;
    res_gidx = '0; res_lidx = '0; res_gpred = 1'b0; res_lpred = 1'b0;
    @(negedge clk);
    fetch_valid = 1'b0; res_valid = 1'b0;
    chk("R10 gidx pre-update", int'(pred_gidx), 0);
    chk("R10 lidx pre-update", int'(pred_lidx), 0);
    chk("R10 lpred pre-update", int'(pred_lpred), 0);
    do_fetch(32'h40);
    chk("R10 global history advanced", int'(pred_gidx), 1);
    chk("R10 local history advanced", int'(pred_lidx), 1);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_global_hist();
    t_local_hist();
    t_global_ctr();
    t_local_ctr();
    t_chooser();
    t_same_cycle();
    report();
  end
endmodule